// File: doc/BRIEF.md
# Rate Search Divider Controller

This block chooses which divider modulus a reclocking PLL uses, and so which data rate the loop tries to acquire. The modulus is given as an index into a small set of states, five by default. In search mode the controller stays on one index for a dwell window of reference-clock cycles. If the loop has input data but has not locked by the end of that window, the controller moves to the next index. After the last index it goes back to the first. It sends out a one-cycle strobe each time it wraps, so that the surrounding logic can count complete sweeps.

Two conditions freeze the index. The first is loss of input data. Because the index is kept, acquisition starts again at the last rate in use when data comes back, and a source switch at the same rate relocks quickly. The second is lock. The index then stays put until lock drops while data is still present. In fixed mode the index follows a value chosen by the user and the stepping is off. The VCO, the sweep ramp and the analog loop are outside this block.

Top module: `rate_search_ctrl`

## Requirements
- R1: While reset is active, and in the first cycle after it, rate_idx is 0 and sweep_strobe is 0. The dwell count starts from zero.
- R2: When auto_mode is 0 and manual_idx is below NUM_STATES, rate_idx equals manual_idx one clock edge later. When auto_mode later goes to 1, the search starts from that index.
- R3: When auto_mode is 0 and manual_idx is NUM_STATES or larger, the value is ignored and rate_idx holds its previous value.
- R4: When auto_mode is 1, data_valid is 1 and locked is 0, rate_idx goes up by one on the DWELL_CYCLES-th consecutive clock edge with those inputs. It does not change on any earlier edge.
- R5: A step from index NUM_STATES-1 wraps to index 0. sweep_strobe is 1 for exactly the cycle that follows that wrapping edge and is 0 in every other cycle.
- R6: When auto_mode is 1 and data_valid is 0, rate_idx is frozen and the dwell count is cleared. After data returns, a full DWELL_CYCLES window passes before the next step, and the search resumes from the frozen index.
- R7: When auto_mode is 1 and locked is 1, rate_idx is frozen and the dwell count is cleared.
- R8: When lock is lost while data is present, the search resumes from the index held during lock and not from index 0.
- R9: rate_idx is always below NUM_STATES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_mode | input | 1 | 1: stepping search, 0: fixed index from manual_idx |
| data_valid | input | 1 | Input data is present |
| locked | input | 1 | The PLL reports lock |
| manual_idx | input | IDX_W | Index requested in fixed mode |
| rate_idx | output | IDX_W | Divider modulus index in use |
| sweep_strobe | output | 1 | One-cycle pulse when the search wraps to index 0 |

## Verification
Every result is registered, so an input held across one clock edge shows at rate_idx and sweep_strobe in the cycle after that edge. A step in search mode shows after the DWELL_CYCLES-th qualifying edge. The bench applies each input set just after a rising edge and waits for the next edge. It then steps a bench-side model of index and dwell count from the requirements, and compares the outputs one time unit later. This way every comparison falls in the cycle where the result is due and away from the edge. A small setup of five states and a four-cycle dwell lets directed runs, a sweep of every manual index and a long pseudo-random run cover each frozen, stepping and wrapping case.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    // Action chosen for the current cycle from mode, data and lock inputs.
    typedef enum logic [1:0] {
        ACT_LOAD   = 2'd0,  // fixed mode: take the user index
        ACT_HOLD   = 2'd1,  // frozen: no data or locked
        ACT_SEARCH = 2'd2   // data present, not locked: count dwell, step
    } rsc_action_e;

endpackage

// File: rtl/rsc_mode_decode.sv
module rsc_mode_decode
    import rsc_pkg::*;
(
    input  logic        auto_mode,
    input  logic        data_valid,
    input  logic        locked,
    output rsc_action_e action
);

    always_comb begin
        if (!auto_mode) begin
            action = ACT_LOAD;
        end else if (!data_valid || locked) begin
            action = ACT_HOLD;
        end else begin
            action = ACT_SEARCH;
        end
    end

endmodule

// File: rtl/rsc_dwell_timer.sv
module rsc_dwell_timer
    import rsc_pkg::*;
#(
    parameter int DWELL_CYCLES = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  rsc_action_e action,
    output logic        expire
);

    localparam int CNT_W = $clog2(DWELL_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DWELL_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_state_t;

    timer_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (action == ACT_SEARCH) begin
            if (st_q.cnt == CNT_LAST) begin
                expire   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            // Any break in the search restarts the dwell window.
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: the count never passes the end of the dwell window.
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_LAST);

    // R6 / R7: a frozen cycle leaves a fresh window behind it.
    p_cnt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (action != ACT_SEARCH) |=> (st_q.cnt == '0));

endmodule

// File: rtl/rsc_rate_stepper.sv
module rsc_rate_stepper
    import rsc_pkg::*;
#(
    parameter int NUM_STATES = 5,
    parameter int IDX_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rsc_action_e      action,
    input  logic             expire,
    input  logic [IDX_W-1:0] manual_idx,
    output logic [IDX_W-1:0] rate_idx,
    output logic             sweep_strobe
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_STATES - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             strobe;
    } step_state_t;

    step_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        unique case (action)
            ACT_LOAD: begin
                if (manual_idx <= IDX_LAST) begin
                    st_d.idx = manual_idx;
                end
            end
            ACT_SEARCH: begin
                if (expire) begin
                    if (st_q.idx == IDX_LAST) begin
                        st_d.idx    = '0;
                        st_d.strobe = 1'b1;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end
            end
            default: begin
                // ACT_HOLD: the index stays as it is
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rate_idx     = st_q.idx;
    assign sweep_strobe = st_q.strobe;

    p_idx_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.idx <= IDX_LAST);

    p_manual_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (action == ACT_LOAD && manual_idx <= IDX_LAST)
            |=> (st_q.idx == $past(manual_idx)));

    p_manual_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (action == ACT_LOAD && manual_idx > IDX_LAST) |=> $stable(st_q.idx));

    p_hold_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (action == ACT_HOLD) |=> $stable(st_q.idx));

    p_no_early_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (action == ACT_SEARCH && !expire) |=> $stable(st_q.idx));

    p_strobe_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.strobe |-> (st_q.idx == '0 && $past(st_q.idx) == IDX_LAST));

endmodule

// File: rtl/rate_search_ctrl.sv
module rate_search_ctrl
    import rsc_pkg::*;
#(
    parameter int NUM_STATES   = 5,
    parameter int DWELL_CYCLES = 1024,
    parameter int IDX_W        = (NUM_STATES > 1) ? $clog2(NUM_STATES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_mode,
    input  logic             data_valid,
    input  logic             locked,
    input  logic [IDX_W-1:0] manual_idx,
    output logic [IDX_W-1:0] rate_idx,
    output logic             sweep_strobe
);

    rsc_action_e action;
    logic        expire;

    rsc_mode_decode u_decode (
        .auto_mode  (auto_mode),
        .data_valid (data_valid),
        .locked     (locked),
        .action     (action)
    );

    rsc_dwell_timer #(
        .DWELL_CYCLES (DWELL_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .action (action),
        .expire (expire)
    );

    rsc_rate_stepper #(
        .NUM_STATES (NUM_STATES),
        .IDX_W      (IDX_W)
    ) u_stepper (
        .clk          (clk),
        .rst_n        (rst_n),
        .action       (action),
        .expire       (expire),
        .manual_idx   (manual_idx),
        .rate_idx     (rate_idx),
        .sweep_strobe (sweep_strobe)
    );

    // R6: loss of data in search mode keeps the index.
    p_nodata_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && !data_valid) |=> $stable(rate_idx));

    // R8: leaving lock with data present does not reset the index.
    p_unlock_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && data_valid && $fell(locked)) |=> $stable(rate_idx));

endmodule

// File: tb/tb_rate_search_ctrl.sv
module tb_rate_search_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NS         = 5;
    localparam int DW         = 4;
    localparam int IW         = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          auto_mode = 1'b0;
    logic          data_valid = 1'b0;
    logic          locked = 1'b0;
    logic [IW-1:0] manual_idx = '0;
    logic [IW-1:0] rate_idx;
    logic          sweep_strobe;

    int n_vec  = 0;
    int n_fail = 0;

    // Bench model state
    int m_idx = 0;
    int m_cnt = 0;
    int m_strobe = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rate_search_ctrl #(
        .NUM_STATES   (NS),
        .DWELL_CYCLES (DW),
        .IDX_W        (IW)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .auto_mode    (auto_mode),
        .data_valid   (data_valid),
        .locked       (locked),
        .manual_idx   (manual_idx),
        .rate_idx     (rate_idx),
        .sweep_strobe (sweep_strobe)
    );

    task automatic check(input string tag);
        n_vec++;
        if (int'(rate_idx) != m_idx || int'(sweep_strobe) != m_strobe) begin
            n_fail++;
            $display("FAIL %s: rate_idx=%0d strobe=%0b expected rate_idx=%0d strobe=%0b",
                     tag, rate_idx, sweep_strobe, m_idx, m_strobe);
        end
    endtask

    // Apply one input set for one clock edge, update the model, compare.
    task automatic step(input logic am, input logic dv, input logic lk,
                        input int man, input string tag);
        auto_mode  = am;
        data_valid = dv;
        locked     = lk;
        manual_idx = IW'(man);
        @(posedge clk);
        m_strobe = 0;
        if (!am) begin
            if (man < NS) m_idx = man;
            m_cnt = 0;
        end else if (!dv || lk) begin
            m_cnt = 0;
        end else if (m_cnt == DW - 1) begin
            m_cnt = 0;
            if (m_idx == NS - 1) begin
                m_idx = 0;
                m_strobe = 1;
            end else begin
                m_idx = m_idx + 1;
            end
        end else begin
            m_cnt = m_cnt + 1;
        end
        #1;
        check(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 during reset");
        rst_n = 1'b1;
        // R1: first cycle after reset, and the dwell count starts from zero
        step(1, 1, 0, 0, "R1");

        // R4 / R5: full sweeps through every state, wrap and strobe
        for (int i = 0; i < 2 * NS * DW + 3; i++) step(1, 1, 0, 0, "R4 R5 sweep");

        // R6: data lost part-way through a window, index frozen, window restarts
        step(1, 1, 0, 0, "R4");
        step(1, 1, 0, 0, "R4");
        for (int i = 0; i < 9; i++) step(1, 0, 0, 0, "R6 freeze");
        for (int i = 0; i < DW + 2; i++) step(1, 1, 0, 0, "R6 resume");

        // R7: lock holds the index; R8: lock loss resumes from there
        step(1, 1, 0, 0, "R4");
        for (int i = 0; i < 3 * DW; i++) step(1, 1, 1, 0, "R7 lock hold");
        for (int i = 0; i < 2 * DW + 1; i++) step(1, 1, 0, 0, "R8 resume");

        // R2 / R3: every manual index, valid and out of range
        for (int v = 0; v < (1 << IW); v++) begin
            step(0, 1, 0, v, (v < NS) ? "R2 manual" : "R3 ignored");
            step(0, 0, 1, v, (v < NS) ? "R2 manual" : "R3 ignored");
        end
        step(0, 1, 0, 3, "R2 manual");
        step(0, 1, 0, 6, "R3 ignored");
        for (int i = 0; i < 3 * DW; i++) step(1, 1, 0, 0, "R2 auto from manual");

        // Mixed pseudo-random traffic: R4 R5 R6 R7 R8 R9
        for (int i = 0; i < 4000; i++) begin
            logic am, dv, lk;
            int   man;
            am  = ($urandom_range(0, 19) != 0);
            dv  = ($urandom_range(0, 9) < 8);
            lk  = ($urandom_range(0, 9) < 2);
            man = $urandom_range(0, (1 << IW) - 1);
            step(am, dv, lk, man, "R9 mixed");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule